// File: doc/BRIEF.md
# Parallel Port Register Block

This block provides the three byte-wide registers of a PC-compatible parallel port behind a small register bus: a data register, a read-only status register and a control register. The data register drives the eight data pads. A read of the data register returns the level actually seen on those pads. The control register drives the four handshake outputs, each with a fixed polarity. It also holds an interrupt enable and a direction bit.

Every input pad passes through a two-stage synchroniser before it is used. This covers the data pads, busy, acknowledge, paper error, select and fault. The status register shows the synchronised inputs, some of them inverted. A rising edge on the synchronised acknowledge line raises a one-cycle interrupt pulse when the enable bit is set.

A mode input selects compatible mode or extended mode. In compatible mode the data drivers are always enabled. In extended mode the direction bit in the control register can turn them off, so that an external device can drive the lines. All outputs come from registers. The data pads are split into input, output and output-enable, as is usual on an FPGA.

Top module: `pport_regs`

## Requirements
- R1: After a synchronous reset, every bus_rdata bit is 0. pad_data_o is 0x00. pad_data_oe is 1. pad_strobe_n, pad_autofd_n and pad_selin_n are 1, pad_init_n is 0 and irq is 0.
- R2: A write to offset 0 sets pad_data_o to the written byte on the same clock edge.
- R3: A read of offset 0 returns the synchronised level on pad_data_i, not the byte last written. A pad change is visible to a read sampled on the third rising edge after the change.
- R4: Control bits 0, 1 and 3 are inverted onto pad_strobe_n, pad_autofd_n and pad_selin_n. The outputs update on the edge that writes offset 2.
- R5: Control bit 2 drives pad_init_n with no inversion.
- R6: A read of offset 2 returns control bits 5..0 as written, and bits 7 and 6 read as 0.
- R7: A read of offset 1 returns the synchronised inputs in this layout: bit 7 is NOT busy, bit 6 is ack_n, bit 5 is paper error, bit 4 is select and bit 3 is fault_n. Bits 2..0 read 0.
- R8: A write to offset 1 has no effect on the status register.
- R9: When ext_mode is 1 and control bit 5 is 1, pad_data_oe is 0. pad_data_oe changes on the edge that writes the control register, or one edge after ext_mode changes.
- R10: When ext_mode is 0, pad_data_oe is 1 whatever control bit 5 holds.
- R11: When control bit 4 is 1, a rising edge on pin_ack_n makes irq high for exactly one cycle. The pulse comes after the third rising clock edge that follows the pin change.
- R12: A falling edge on pin_ack_n never raises irq, and neither does any edge while control bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset (0 data, 1 status, 2 control) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_mode | input | 1 | 1 selects extended mode, 0 selects compatible mode |
| pad_data_i | input | 8 | Level on the data pads |
| pad_data_o | output | 8 | Value driven on the data pads |
| pad_data_oe | output | 1 | Data pad driver enable |
| pad_strobe_n | output | 1 | Active-low strobe |
| pad_autofd_n | output | 1 | Active-low auto feed |
| pad_init_n | output | 1 | Active-low initialise |
| pad_selin_n | output | 1 | Active-low select-in |
| pin_busy | input | 1 | Busy input |
| pin_ack_n | input | 1 | Active-low acknowledge input |
| pin_perror | input | 1 | Paper error input |
| pin_select | input | 1 | Select input |
| pin_fault_n | input | 1 | Active-low fault input |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Register writes reach their pads on the writing edge, so the bench checks the pads just after that edge. A read returns data on the edge that samples bus_rd, so the bench reads bus_rdata on the next falling edge. A change on an input pad needs two synchroniser edges before a read can see it. The bench therefore waits three clocks after any pad change before it issues the read. For the interrupt, the bench records irq at the falling edge after each of six clocks that follow a pin change. It then checks that the only high sample is the one after the third edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;

  localparam int CB_STB   = 0;
  localparam int CB_AFD   = 1;
  localparam int CB_INIT  = 2;
  localparam int CB_SELIN = 3;
  localparam int CB_IRQEN = 4;
  localparam int CB_DIR   = 5;
  localparam int CTRL_W   = 6;

  localparam int STAT_W   = 5;

  typedef struct packed {
    logic busy;
    logic ack_n;
    logic perror;
    logic select;
    logic fault_n;
  } pin_stat_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pport_rise_irq.sv
module pport_rise_irq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      prev_q <= lvl;
      pulse  <= en & lvl & ~prev_q;
    end
  end
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
  import pport_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ext_mode,
  input  logic [DW-1:0] data_s,
  input  pin_stat_t     stat_s,
  output logic [DW-1:0] data_q,
  output logic          oe,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n,
  output logic          selin_n,
  output logic          irq_en
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic              wr_data, wr_ctrl;
  logic [DW-1:0]     rd_mux, stat_word, ctrl_word;

  assign wr_data = wr && (addr == AW'(OFS_DATA));
  assign wr_ctrl = wr && (addr == AW'(OFS_CTRL));
  assign ctrl_nx = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      ctrl_q   <= '0;
      oe       <= 1'b1;
      strobe_n <= 1'b1;
      autofd_n <= 1'b1;
      init_n   <= 1'b0;
      selin_n  <= 1'b1;
    end else begin
      if (wr_data) data_q <= wdata;
      ctrl_q   <= ctrl_nx;
      oe       <= ~(ext_mode & ctrl_nx[CB_DIR]);
      strobe_n <= ~ctrl_nx[CB_STB];
      autofd_n <= ~ctrl_nx[CB_AFD];
      init_n   <=  ctrl_nx[CB_INIT];
      selin_n  <= ~ctrl_nx[CB_SELIN];
    end
  end

  assign irq_en = ctrl_q[CB_IRQEN];

  always_comb begin
    stat_word    = '0;
    stat_word[7] = ~stat_s.busy;
    stat_word[6] = stat_s.ack_n;
    stat_word[5] = stat_s.perror;
    stat_word[4] = stat_s.select;
    stat_word[3] = stat_s.fault_n;
    ctrl_word    = '0;
    ctrl_word[CTRL_W-1:0] = ctrl_q;
    case (addr)
      AW'(OFS_DATA): rd_mux = data_s;
      AW'(OFS_STAT): rd_mux = stat_word;
      AW'(OFS_CTRL): rd_mux = ctrl_word;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_mode,
  input  logic [DATA_W-1:0] pad_data_i,
  output logic [DATA_W-1:0] pad_data_o,
  output logic              pad_data_oe,
  output logic              pad_strobe_n,
  output logic              pad_autofd_n,
  output logic              pad_init_n,
  output logic              pad_selin_n,
  input  logic              pin_busy,
  input  logic              pin_ack_n,
  input  logic              pin_perror,
  input  logic              pin_select,
  input  logic              pin_fault_n,
  output logic              irq
);
  localparam int IN_W = DATA_W + STAT_W;

  pin_stat_t         stat_raw, stat_s;
  logic [DATA_W-1:0] data_s;
  logic [IN_W-1:0]   in_raw, in_s;
  logic              irq_en;

  assign stat_raw = '{busy: pin_busy, ack_n: pin_ack_n, perror: pin_perror,
                      select: pin_select, fault_n: pin_fault_n};
  assign in_raw   = {pad_data_i, stat_raw};

  pport_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(in_raw), .q(in_s)
  );

  assign data_s = in_s[IN_W-1:STAT_W];
  assign stat_s = in_s[STAT_W-1:0];

  pport_regfile #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .ext_mode(ext_mode),
    .data_s(data_s), .stat_s(stat_s), .data_q(pad_data_o),
    .oe(pad_data_oe), .strobe_n(pad_strobe_n), .autofd_n(pad_autofd_n),
    .init_n(pad_init_n), .selin_n(pad_selin_n), .irq_en(irq_en)
  );

  pport_rise_irq u_irq (
    .clk(clk), .rst(rst), .en(irq_en), .lvl(stat_s.ack_n), .pulse(irq)
  );
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ext_mode,
  input logic [DATA_W-1:0] pad_data_o,
  input logic              pad_data_oe,
  input logic              pad_strobe_n,
  input logic              pad_init_n,
  input logic              irq
);
  AST_DATA_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (pad_data_o == $past(bus_wdata))); // R2
  AST_STROBE_INV: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> (pad_strobe_n == !$past(bus_wdata[0]))); // R4
  AST_INIT_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> (pad_init_n == $past(bus_wdata[2]))); // R5
  AST_COMPAT_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode) |=> pad_data_oe); // R10
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R11
endmodule

bind pport_regs pport_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .ext_mode(ext_mode), .pad_data_o(pad_data_o),
  .pad_data_oe(pad_data_oe), .pad_strobe_n(pad_strobe_n),
  .pad_init_n(pad_init_n), .irq(irq)
);

// File: tb/tb_pport_regs.sv
module tb_pport_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_mode = 1'b0;
  logic [7:0] pad_data_i, pad_data_o, ext_drive = 8'h00;
  logic       pad_data_oe, pad_strobe_n, pad_autofd_n, pad_init_n, pad_selin_n;
  logic       pin_busy = 1'b0, pin_ack_n = 1'b1, pin_perror = 1'b0;
  logic       pin_select = 1'b0, pin_fault_n = 1'b1;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pad_data_i = pad_data_oe ? pad_data_o : ext_drive;

  pport_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_mode(ext_mode),
    .pad_data_i(pad_data_i), .pad_data_o(pad_data_o), .pad_data_oe(pad_data_oe),
    .pad_strobe_n(pad_strobe_n), .pad_autofd_n(pad_autofd_n),
    .pad_init_n(pad_init_n), .pad_selin_n(pad_selin_n), .pin_busy(pin_busy),
    .pin_ack_n(pin_ack_n), .pin_perror(pin_perror), .pin_select(pin_select),
    .pin_fault_n(pin_fault_n), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 data_o", pad_data_o, 8'h00);
    check("R1 pins", {3'b0, pad_data_oe, pad_strobe_n, pad_autofd_n, pad_init_n, pad_selin_n},
          8'b0001_1101);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] r;
    bus_write(2'd0, 8'h5A);
    check("R2 drive", pad_data_o, 8'h5A);
    idle(3);
    bus_read(2'd0, r);
    check("R3 loop read", r, 8'h5A);
    bus_write(2'd0, 8'hC3);
    check("R2 drive2", pad_data_o, 8'hC3);
  endtask

  task automatic t_ctrl();
    logic [7:0] r;
    bus_write(2'd2, 8'hC5);
    check("R4 strobe_n", {7'b0, pad_strobe_n}, 8'h00);
    check("R4 autofd_n", {7'b0, pad_autofd_n}, 8'h01);
    check("R4 selin_n", {7'b0, pad_selin_n}, 8'h01);
    check("R5 init_n", {7'b0, pad_init_n}, 8'h01);
    bus_read(2'd2, r);
    check("R6 readback", r, 8'h05);
    bus_write(2'd2, 8'h0A);
    check("R4 autofd_n2", {7'b0, pad_autofd_n}, 8'h00);
    check("R4 selin_n2", {7'b0, pad_selin_n}, 8'h00);
    check("R5 init_n2", {7'b0, pad_init_n}, 8'h00);
    bus_read(2'd2, r);
    check("R6 readback2", r, 8'h0A);
  endtask

  task automatic t_status();
    logic [7:0] r;
    pin_busy = 1'b1; pin_ack_n = 1'b0; pin_perror = 1'b1;
    pin_select = 1'b0; pin_fault_n = 1'b1;
    idle(3);
    bus_read(2'd1, r);
    check("R7 status a", r, 8'b0010_1000);
    pin_busy = 1'b0; pin_ack_n = 1'b1; pin_perror = 1'b0;
    pin_select = 1'b1; pin_fault_n = 1'b0;
    idle(3);
    bus_read(2'd1, r);
    check("R7 status b", r, 8'b1101_0000);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, r);
    check("R8 status write ignored", r, 8'b1101_0000);
    bus_read(2'd2, r);
    check("R8 ctrl untouched", r, 8'h0A);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    ext_mode = 1'b1;
    bus_write(2'd2, 8'h20);
    check("R9 oe off", {7'b0, pad_data_oe}, 8'h00);
    ext_drive = 8'hA5;
    idle(3);
    bus_read(2'd0, r);
    check("R3 reads pins", r, 8'hA5);
    check("R3 latch kept", pad_data_o, 8'hC3);
    ext_mode = 1'b0;
    idle(1);
    check("R10 compat oe", {7'b0, pad_data_oe}, 8'h01);
    ext_mode = 1'b1;
    idle(1);
    check("R9 ext oe", {7'b0, pad_data_oe}, 8'h00);
    bus_write(2'd2, 8'h00);
    check("R9 dir clear", {7'b0, pad_data_oe}, 8'h01);
    ext_mode = 1'b0;
  endtask

  task automatic t_irq();
    logic [7:0] seen;
    int hits;
    bus_write(2'd2, 8'h10);
    pin_ack_n = 1'b0;
    idle(4);
    pin_ack_n = 1'b1;
    seen = '0; hits = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq) begin hits++; seen[i] = 1'b1; end
    end
    check("R11 pulse timing", seen, 8'b0000_0100);
    check("R11 pulse count", 8'(hits), 8'd1);
    pin_ack_n = 1'b0;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    check("R12 falling edge", 8'(hits), 8'd0);
    bus_write(2'd2, 8'h00);
    pin_ack_n = 1'b1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    check("R12 disabled", 8'(hits), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_data();
    t_ctrl();
    t_status();
    t_direction();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule